// File: doc/BRIEF.md
# Fabric Configuration Sequencer

This block runs a full passive-parallel bring-up of an attached programmable fabric without a processor stepping through it. A single start pulse launches a fixed sequence. The sequence first checks that host control is granted and that the fabric is powered. It then turns a 4-bit mode-select code into a bus width and a clock-to-data ratio, drives chip-enable low and pulls the fabric into reset. It waits for the reset and configuration phases, clears the pending status interrupt and opens a data window.

While the window is open, words from a valid/ready stream pass straight through to the fabric. The sequencer then waits for the completion flags, closes the window and asks an external pulse generator for a short burst of trailing clocks. Last, it waits for the fabric to enter user mode. Each wait has its own poll limit. The run ends with a one-cycle done pulse and a 3-bit result code, which holds until the next run finishes.

Stream rules: `s_ready` is high only while the sequencer accepts data, and never depends on `s_valid`. A beat transfers on a clock edge where both are high. The source may hold `s_valid` low for any number of cycles, and it keeps data, last and byte count stable until the beat transfers. Back-pressure comes only from the sequencer's phase: before the window opens and after it closes, `s_ready` stays low.

Top module: `fabric_cfg_seq`

## Requirements
- R1: For a legal mode-select code, `cfg_width32` and `cfg_ratio` are loaded before the reset pull rises. Codes 0,1,2,4,5,6 give width 16 (`cfg_width32`=0) with ratios 1,2,4,1,2,4. Codes 8,9,10,12,13,14 give width 32 (`cfg_width32`=1) with ratios 1,4,8,1,4,8. `cfg_ratio` carries the ratio value itself.
- R2: Codes 3,7,11,15 end the run with result 3 and the reset pull never asserts.
- R3: If `host_en` is low at start, the result is 1. Otherwise, if `fab_pwr_on` is low, the result is 2. Either refusal gives `done` in the cycle after start is sampled.
- R4: The sequence runs in this order. First `cfg_nce` goes low. Then `cfg_reset_pull` rises and stays high until `fab_phase` reads 1 (reset). Then the pull is released and the sequencer waits for `fab_phase` 2 (configuring). Then `nstatus_clr` pulses for one cycle while the pull is low. In the next cycle `data_win_en` rises.
- R5: If the reset phase is not seen within 2048 cycles, the pull is held for exactly 2048 cycles and then released. The run ends with result 4, with the pull already low at `done`.
- R6: A beat is forwarded on `data_out` with `data_out_vld` in the cycle it transfers. On a beat with `s_last`=1, `s_bytes` gives the count of valid low bytes (0 means 4, 1 to 3 mean that many) and the upper lanes are zero. Non-final beats pass all four bytes.
- R7: The total accepted bytes may reach the cap (`CAP_BYTES`, default 32 MiB) but not exceed it. A beat that would exceed the cap is consumed but not forwarded, the window closes and the data-phase error becomes 4.
- R8: After the last beat, the sequencer polls the completion flags for up to 8192 cycles. `fab_crc_err` gives a data-phase error of 5. `fab_conf_done`=`fab_nstatus`=1 means success. Both low gives 4. A timeout gives 4.
- R9: After the window closes, `dclk_req` pulses with `dclk_cnt`=4. The sequencer waits up to 2056 cycles for `dclk_done`, then up to 2048 cycles for `fab_phase` 4 (user). A timeout in either wait ends the run.
- R10: The final result is the data-phase error whenever one exists, both on a late timeout and on a clean finish. Only if the data phase was clean does a late timeout give 4. Otherwise the result is 0.
- R11: `busy` is high from the cycle after start until `done`. `done` lasts one cycle. `result` changes only in a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration run (ignored while busy) |
| host_en | input | 1 | Host holds control of the configuration block |
| mode_sel | input | 4 | Mode-select code from the fabric strap pins |
| fab_pwr_on | input | 1 | Fabric reports power good |
| fab_phase | input | 3 | Fabric phase: 1 reset, 2 configuring, 4 user |
| fab_conf_done | input | 1 | Fabric configuration-done flag |
| fab_nstatus | input | 1 | Fabric status flag (low means error) |
| fab_crc_err | input | 1 | Fabric reports a CRC error |
| dclk_done | input | 1 | Trailing-clock burst complete |
| s_data | input | 32 | Configuration data word |
| s_valid | input | 1 | Data word valid |
| s_last | input | 1 | Final word of the image |
| s_bytes | input | 2 | Valid bytes on the final word (0 = 4) |
| s_ready | output | 1 | Sequencer accepts a word |
| data_out | output | 32 | Word forwarded to the fabric |
| data_out_vld | output | 1 | Forwarded word valid |
| data_win_en | output | 1 | Data window to the fabric open |
| cfg_width32 | output | 1 | Bus width 32 when high, 16 when low |
| cfg_ratio | output | 4 | Clock-to-data ratio (1, 2, 4 or 8) |
| cfg_nce | output | 1 | Fabric chip-enable, active low |
| cfg_reset_pull | output | 1 | Request the fabric into configuration reset |
| nstatus_clr | output | 1 | One-cycle clear of the pending status interrupt |
| dclk_req | output | 1 | One-cycle request for a trailing-clock burst |
| dclk_cnt | output | 16 | Number of trailing clocks requested |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle run-complete pulse |
| result | output | 3 | 0 ok, 1 no control, 2 power off, 3 bad mode, 4 config error, 5 CRC error |

## Verification
A refusal produces `done` exactly one cycle after start is sampled. A forwarded word appears on `data_out` in the same cycle it transfers. Every timeout fires after exactly its limit of wait cycles, so the reset-pull width of 2048 is counted cycle by cycle. The bench drives inputs and samples outputs on falling edges. Its scoreboard pops an expected result only on a `done` cycle and an expected word only on a `data_out_vld` cycle. The sequencing checks sit at the cycle each event must occur: width and ratio at the pull's first cycle, the fabric phase at the interrupt clear, and the clear one cycle before the window opens.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [2:0] {
    RES_OK       = 3'd0,
    RES_NO_CTRL  = 3'd1,
    RES_PWR_OFF  = 3'd2,
    RES_BAD_MODE = 3'd3,
    RES_CFG_ERR  = 3'd4,
    RES_CRC_ERR  = 3'd5
  } res_e;

  localparam logic [2:0] PH_RESET  = 3'd1;
  localparam logic [2:0] PH_CONFIG = 3'd2;
  localparam logic [2:0] PH_USER   = 3'd4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROG,
    ST_WAIT_RST,
    ST_WAIT_CFG,
    ST_CLR_NS,
    ST_DATA,
    ST_WAIT_DONE,
    ST_CLOSE,
    ST_DCLK,
    ST_WAIT_DCLK,
    ST_WAIT_USER,
    ST_FIN
  } st_e;

  typedef struct packed {
    logic       legal;
    logic       wide;
    logic [3:0] ratio;
  } mode_t;

endpackage

// File: rtl/fcs_mode_decode.sv
module fcs_mode_decode
  import fcs_pkg::*;
(
  input  logic [3:0] code,
  output mode_t      mode
);
  logic [1:0] step;
  logic       unused_speed;

  assign step         = code[1:0];
  assign unused_speed = code[2];

  always_comb begin
    mode.legal = (step != 2'd3);
    mode.wide  = code[3];
    if (!code[3]) begin
      mode.ratio = 4'd1 << step;
    end else if (step == 2'd0) begin
      mode.ratio = 4'd1;
    end else begin
      mode.ratio = 4'd1 << (step + 2'd1);
    end
  end
endmodule

// File: rtl/fcs_poll_timer.sv
module fcs_poll_timer #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == limit - 1'b1);
endmodule

// File: rtl/fcs_data_window.sv
module fcs_data_window #(
  parameter int  DW        = 32,
  parameter int  CAP_BYTES = 32 * 1024 * 1024,
  localparam int NB        = DW / 8,
  localparam int BW        = $clog2(NB),
  localparam int CW        = $clog2(CAP_BYTES + 1) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [DW-1:0] s_data,
  input  logic          s_valid,
  input  logic          s_last,
  input  logic [BW-1:0] s_bytes,
  output logic          s_ready,
  output logic [DW-1:0] fwd_data,
  output logic          fwd_vld,
  output logic          end_ok,
  output logic          over
);
  logic [CW-1:0] tot_q;
  logic [CW:0]   sum;
  logic [BW:0]   nbytes;
  logic          take;

  assign s_ready = en;
  assign take    = en && s_valid;

  always_comb begin
    if (s_last && s_bytes != '0) nbytes = {1'b0, s_bytes};
    else                         nbytes = (BW+1)'(NB);
  end

  assign sum  = {1'b0, tot_q} + (CW+1)'(nbytes);
  assign over = take && (sum > (CW+1)'(CAP_BYTES));

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic keep;
    assign keep = !s_last || (s_bytes == '0) || (i < int'(s_bytes));
    assign fwd_data[8*i +: 8] = keep ? s_data[8*i +: 8] : 8'h00;
  end

  assign fwd_vld = take && !over;
  assign end_ok  = take && !over && s_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tot_q <= '0;
    else if (clr)     tot_q <= '0;
    else if (fwd_vld) tot_q <= sum[CW-1:0];
  end
endmodule

// File: rtl/fabric_cfg_seq.sv
module fabric_cfg_seq
  import fcs_pkg::*;
#(
  parameter int PHASE_POLLS = 2048,
  parameter int DONE_POLLS  = 8192,
  parameter int TRAIL_CLKS  = 4,
  parameter int DCLK_POLLS  = 2048 + 2 * TRAIL_CLKS,
  parameter int CAP_BYTES   = 32 * 1024 * 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        host_en,
  input  logic [3:0]  mode_sel,
  input  logic        fab_pwr_on,
  input  logic [2:0]  fab_phase,
  input  logic        fab_conf_done,
  input  logic        fab_nstatus,
  input  logic        fab_crc_err,
  input  logic        dclk_done,
  input  logic [31:0] s_data,
  input  logic        s_valid,
  input  logic        s_last,
  input  logic [1:0]  s_bytes,
  output logic        s_ready,
  output logic [31:0] data_out,
  output logic        data_out_vld,
  output logic        data_win_en,
  output logic        cfg_width32,
  output logic [3:0]  cfg_ratio,
  output logic        cfg_nce,
  output logic        cfg_reset_pull,
  output logic        nstatus_clr,
  output logic        dclk_req,
  output logic [15:0] dclk_cnt,
  output logic        busy,
  output logic        done,
  output logic [2:0]  result
);
  localparam int MAXP  = (DONE_POLLS > DCLK_POLLS) ?
                         ((DONE_POLLS > PHASE_POLLS) ? DONE_POLLS : PHASE_POLLS) :
                         ((DCLK_POLLS > PHASE_POLLS) ? DCLK_POLLS : PHASE_POLLS);
  localparam int TW    = $clog2(MAXP + 1);

  st_e        state_q, state_d;
  res_e       res_q, res_d;
  res_e       derr_q, derr_d;
  res_e       late_err;
  mode_t      mode;
  logic [TW-1:0] limit;
  logic       expired;
  logic       end_ok, over;
  logic       load_cfg;

  fcs_mode_decode u_dec (
    .code (mode_sel),
    .mode (mode)
  );

  always_comb begin
    unique case (state_q)
      ST_WAIT_DONE: limit = TW'(DONE_POLLS);
      ST_WAIT_DCLK: limit = TW'(DCLK_POLLS);
      default:      limit = TW'(PHASE_POLLS);
    endcase
  end

  fcs_poll_timer #(.CW(TW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (state_d != state_q),
    .limit   (limit),
    .expired (expired)
  );

  fcs_data_window #(.DW(32), .CAP_BYTES(CAP_BYTES)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (state_q == ST_PROG),
    .en       (state_q == ST_DATA),
    .s_data   (s_data),
    .s_valid  (s_valid),
    .s_last   (s_last),
    .s_bytes  (s_bytes),
    .s_ready  (s_ready),
    .fwd_data (data_out),
    .fwd_vld  (data_out_vld),
    .end_ok   (end_ok),
    .over     (over)
  );

  assign late_err = (derr_q != RES_OK) ? derr_q : RES_CFG_ERR;

  always_comb begin
    state_d  = state_q;
    res_d    = res_q;
    derr_d   = derr_q;
    load_cfg = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_FIN;
        derr_d  = RES_OK;
        if (!host_en)         res_d = RES_NO_CTRL;
        else if (!fab_pwr_on) res_d = RES_PWR_OFF;
        else if (!mode.legal) res_d = RES_BAD_MODE;
        else begin
          state_d  = ST_PROG;
          load_cfg = 1'b1;
        end
      end
      ST_PROG: state_d = ST_WAIT_RST;
      ST_WAIT_RST: begin
        if (fab_phase == PH_RESET) state_d = ST_WAIT_CFG;
        else if (expired) begin
          state_d = ST_FIN;
          res_d   = RES_CFG_ERR;
        end
      end
      ST_WAIT_CFG: begin
        if (fab_phase == PH_CONFIG) state_d = ST_CLR_NS;
        else if (expired) begin
          state_d = ST_FIN;
          res_d   = RES_CFG_ERR;
        end
      end
      ST_CLR_NS: state_d = ST_DATA;
      ST_DATA: begin
        if (over) begin
          derr_d  = RES_CFG_ERR;
          state_d = ST_CLOSE;
        end else if (end_ok) begin
          state_d = ST_WAIT_DONE;
        end
      end
      ST_WAIT_DONE: begin
        if (fab_crc_err) begin
          derr_d  = RES_CRC_ERR;
          state_d = ST_CLOSE;
        end else if (fab_conf_done == fab_nstatus) begin
          derr_d  = fab_conf_done ? RES_OK : RES_CFG_ERR;
          state_d = ST_CLOSE;
        end else if (expired) begin
          derr_d  = RES_CFG_ERR;
          state_d = ST_CLOSE;
        end
      end
      ST_CLOSE: state_d = ST_DCLK;
      ST_DCLK:  state_d = ST_WAIT_DCLK;
      ST_WAIT_DCLK: begin
        if (dclk_done) state_d = ST_WAIT_USER;
        else if (expired) begin
          state_d = ST_FIN;
          res_d   = late_err;
        end
      end
      ST_WAIT_USER: begin
        if (fab_phase == PH_USER) begin
          state_d = ST_FIN;
          res_d   = derr_q;
        end else if (expired) begin
          state_d = ST_FIN;
          res_d   = late_err;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      res_q       <= RES_OK;
      derr_q      <= RES_OK;
      cfg_width32 <= 1'b0;
      cfg_ratio   <= 4'd1;
      cfg_nce     <= 1'b1;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      derr_q  <= derr_d;
      if (load_cfg) begin
        cfg_width32 <= mode.wide;
        cfg_ratio   <= mode.ratio;
        cfg_nce     <= 1'b0;
      end
    end
  end

  assign cfg_reset_pull = (state_q == ST_WAIT_RST);
  assign nstatus_clr    = (state_q == ST_CLR_NS);
  assign data_win_en    = (state_q == ST_DATA) || (state_q == ST_WAIT_DONE);
  assign dclk_req       = (state_q == ST_DCLK);
  assign dclk_cnt       = 16'(TRAIL_CLKS);
  assign busy           = (state_q != ST_IDLE);
  assign done           = (state_q == ST_FIN);
  assign result         = res_q;
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [2:0] result,
  input logic       cfg_reset_pull,
  input logic       cfg_nce,
  input logic       nstatus_clr,
  input logic       data_win_en,
  input logic       s_valid,
  input logic       s_ready,
  input logic       data_out_vld,
  input logic       dclk_req
);
  AST_WIN_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_win_en && cfg_reset_pull)); // R4
  AST_PULL_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_reset_pull) |-> !cfg_nce); // R4
  AST_CLR_BEFORE_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_win_en) |-> $past(nstatus_clr)); // R4
  AST_READY_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> data_win_en); // R6
  AST_FWD_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    data_out_vld |-> (s_valid && s_ready)); // R6
  AST_DCLK_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_req |-> (!data_win_en && $past(!data_win_en))); // R9
  AST_PULL_LOW_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cfg_reset_pull); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R11
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R11
endmodule

bind fabric_cfg_seq fcs_checker u_fcs_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .start          (start),
  .busy           (busy),
  .done           (done),
  .result         (result),
  .cfg_reset_pull (cfg_reset_pull),
  .cfg_nce        (cfg_nce),
  .nstatus_clr    (nstatus_clr),
  .data_win_en    (data_win_en),
  .s_valid        (s_valid),
  .s_ready        (s_ready),
  .data_out_vld   (data_out_vld),
  .dclk_req       (dclk_req)
);

// File: tb/test_fabric_cfg_seq.sv
module test_fabric_cfg_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, host_en = 1'b0, fab_pwr_on = 1'b0;
  logic [3:0]  mode_sel = '0;
  logic [2:0]  fab_phase = '0;
  logic        fab_conf_done = 1'b0, fab_nstatus = 1'b0, fab_crc_err = 1'b0;
  logic        dclk_done = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_valid = 1'b0, s_last = 1'b0;
  logic [1:0]  s_bytes = '0;
  logic        s_ready, data_out_vld, data_win_en, cfg_width32, cfg_nce;
  logic        cfg_reset_pull, nstatus_clr, dclk_req, busy, done;
  logic [31:0] data_out;
  logic [3:0]  cfg_ratio;
  logic [15:0] dclk_cnt;
  logic [2:0]  result;

  int checks = 0, fails = 0;
  int done_cnt = 0, pull_rises = 0, pull_len = 0;
  logic [2:0]  res_q[$];
  string       req_q[$];
  logic [31:0] dat_q[$];
  logic        exp_w = 1'b0;
  logic [3:0]  exp_r = '0;
  logic        model_clear = 1'b0, no_reset = 1'b0, no_dclk = 1'b0, no_user = 1'b0;
  logic        done_p = 1'b0, pull_p = 1'b0, clr_p = 1'b0, win_p = 1'b0;
  logic [2:0]  last_res = '0;
  int          dly = 0, dcnt = 0;

  always #2 clk = ~clk;

  fabric_cfg_seq #(.CAP_BYTES(64)) i_fabric_cfg_seq (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Fabric and clock-burst model
  always @(posedge clk) begin
    dclk_done <= 1'b0;
    if (model_clear) begin
      fab_phase <= 3'd0; dly = 0; dcnt = 0;
    end else begin
      if (cfg_reset_pull) begin
        if (!no_reset) begin
          dly = dly + 1;
          if (dly >= 3) fab_phase <= 3'd1;
        end
      end else begin
        dly = 0;
        if (fab_phase == 3'd1) fab_phase <= 3'd2;
      end
      if (dclk_req && !no_dclk) dcnt = 5;
      else if (dcnt > 0) begin
        dcnt = dcnt - 1;
        if (dcnt == 0) begin
          dclk_done <= 1'b1;
          if (!no_user) fab_phase <= 3'd4;
        end
      end
    end
  end

  // Monitor and scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (data_out_vld) begin
        if (dat_q.size() == 0) chk(0, "R6", "unexpected word", data_out, 0);
        else begin
          logic [31:0] e;
          e = dat_q.pop_front();
          chk(data_out == e, "R6", "forwarded word", data_out, e);
        end
      end
      if (done) begin
        chk(!done_p, "R11", "done width", 2, 1);
        chk(!cfg_reset_pull, "R5", "pull at done", cfg_reset_pull, 0);
        if (res_q.size() == 0) chk(0, "R11", "unexpected done", result, 0);
        else begin
          logic [2:0] e;
          string r;
          e = res_q.pop_front();
          r = req_q.pop_front();
          chk(result == e, r, "result", result, e);
        end
        last_res = result;
        done_cnt++;
      end else if (result != last_res) begin
        chk(0, "R11", "result moved without done", result, last_res);
        last_res = result;
      end
      if (cfg_reset_pull) pull_len++;
      if (cfg_reset_pull && !pull_p) begin
        pull_rises++;
        chk(cfg_width32 == exp_w, "R1", "width", cfg_width32, exp_w);
        chk(cfg_ratio == exp_r, "R1", "ratio", cfg_ratio, exp_r);
        chk(!cfg_nce, "R4", "chip enable before pull", cfg_nce, 0);
      end
      if (nstatus_clr)
        chk(fab_phase == 3'd2 && !cfg_reset_pull, "R4", "clear in config phase",
            {fab_phase, cfg_reset_pull}, 4);
      if (data_win_en && !win_p)
        chk(clr_p, "R4", "clear precedes window", clr_p, 1);
      if (dclk_req)
        chk(dclk_cnt == 16'd4 && !data_win_en, "R9", "trailing request",
            {data_win_en, dclk_cnt}, 4);
    end
    done_p = done; pull_p = cfg_reset_pull; clr_p = nstatus_clr; win_p = data_win_en;
  end

  function automatic logic [31:0] lane_mask(input logic [31:0] w, input logic last,
                                            input logic [1:0] nb);
    if (!last || nb == 2'd0) return w;
    case (nb)
      2'd1:    return {24'h0, w[7:0]};
      2'd2:    return {16'h0, w[15:0]};
      default: return {8'h0, w[23:0]};
    endcase
  endfunction

  function automatic logic [3:0] ratio_of(input logic [3:0] m);
    case (m)
      4'd0, 4'd4, 4'd8, 4'd12: return 4'd1;
      4'd1, 4'd5:              return 4'd2;
      4'd2, 4'd6, 4'd9, 4'd13: return 4'd4;
      4'd10, 4'd14:            return 4'd8;
      default:                 return 4'd0;
    endcase
  endfunction

  task automatic run(input string req, input logic [3:0] m, input logic en, input logic pwr,
                     input int nw, input logic [1:0] lb, input int nfwd,
                     input logic cd, input logic ns, input logic ce,
                     input logic nr, input logic nd, input logic nu,
                     input logic [2:0] exp_res);
    int d0;
    host_en = en; fab_pwr_on = pwr; mode_sel = m;
    fab_conf_done = cd; fab_nstatus = ns; fab_crc_err = ce;
    no_reset = nr; no_dclk = nd; no_user = nu;
    exp_w = m[3]; exp_r = ratio_of(m);
    model_clear = 1'b1;
    @(negedge clk);
    model_clear = 1'b0;
    pull_rises = 0; pull_len = 0;
    res_q.push_back(exp_res); req_q.push_back(req);
    d0 = done_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (exp_res inside {3'd1, 3'd2, 3'd3})
      chk(done == 1'b1, "R3", "refusal timing", done, 1);
    for (int i = 0; i < nw; i++) begin
      s_data  = {8'hC0 + 8'(i), 8'h5A, 8'(m), 8'h11 + 8'(i)};
      s_last  = (i == nw - 1);
      s_bytes = s_last ? lb : 2'd0;
      s_valid = 1'b1;
      if (i < nfwd) dat_q.push_back(lane_mask(s_data, s_last, s_bytes));
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0;
    while (done_cnt == d0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && result == 3'd0, "R11", "reset outputs", {busy, done, result}, 0);
    chk(cfg_nce && !cfg_reset_pull && !s_ready && !data_win_en, "R4", "reset controls",
        {cfg_nce, cfg_reset_pull, s_ready, data_win_en}, 8);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 refusals, enable has priority over power
    run("R3", 4'd0, 1'b0, 1'b0, 0, 2'd0, 0, 1, 1, 0, 0, 0, 0, 3'd1);
    run("R3", 4'd0, 1'b1, 1'b0, 0, 2'd0, 0, 1, 1, 0, 0, 0, 0, 3'd2);
    // R1 / R2 every mode code
    for (int c = 0; c < 16; c++) begin
      if (c[1:0] == 2'b11) begin
        run("R2", 4'(c), 1'b1, 1'b1, 0, 2'd0, 0, 1, 1, 0, 0, 0, 0, 3'd3);
        chk(pull_rises == 0, "R2", "pull on bad mode", pull_rises, 0);
      end else begin
        run("R1", 4'(c), 1'b1, 1'b1, 1, 2'd0, 1, 1, 1, 0, 0, 0, 0, 3'd0);
      end
    end
    // R6 partial final beats
    run("R6", 4'd9, 1'b1, 1'b1, 3, 2'd2, 3, 1, 1, 0, 0, 0, 0, 3'd0);
    run("R6", 4'd6, 1'b1, 1'b1, 4, 2'd1, 4, 1, 1, 0, 0, 0, 0, 3'd0);
    run("R6", 4'd12, 1'b1, 1'b1, 2, 2'd3, 2, 1, 1, 0, 0, 0, 0, 3'd0);
    // R7 cap of 64 bytes: exactly at cap, and one beat past it
    run("R7", 4'd8, 1'b1, 1'b1, 16, 2'd0, 16, 1, 1, 0, 0, 0, 0, 3'd0);
    run("R7", 4'd8, 1'b1, 1'b1, 17, 2'd0, 16, 1, 1, 0, 0, 0, 0, 3'd4);
    chk(dat_q.size() == 0, "R7", "words left over", dat_q.size(), 0);
    // R8 completion flags
    run("R8", 4'd0, 1'b1, 1'b1, 1, 2'd0, 1, 1, 1, 1, 0, 0, 0, 3'd5);
    run("R8", 4'd0, 1'b1, 1'b1, 1, 2'd0, 1, 0, 0, 0, 0, 0, 0, 3'd4);
    run("R8", 4'd0, 1'b1, 1'b1, 1, 2'd0, 1, 1, 0, 0, 0, 0, 0, 3'd4);
    // R5 reset phase never reported
    run("R5", 4'd1, 1'b1, 1'b1, 0, 2'd0, 0, 1, 1, 0, 1, 0, 0, 3'd4);
    chk(pull_len == 2048, "R5", "pull width", pull_len, 2048);
    // R9 late timeouts on a clean data phase
    run("R9", 4'd2, 1'b1, 1'b1, 1, 2'd0, 1, 1, 1, 0, 0, 1, 0, 3'd4);
    run("R9", 4'd2, 1'b1, 1'b1, 1, 2'd0, 1, 1, 1, 0, 0, 0, 1, 3'd4);
    // R10 data error wins over a late timeout
    run("R10", 4'd10, 1'b1, 1'b1, 1, 2'd0, 1, 1, 1, 1, 0, 0, 1, 3'd5);
    run("R10", 4'd10, 1'b1, 1'b1, 1, 2'd0, 1, 1, 1, 1, 0, 1, 0, 3'd5);
    chk(res_q.size() == 0, "R11", "results outstanding", res_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule